// File: doc/BRIEF.md
# Packed Media Integer ALU

This block is a single-stage arithmetic unit for audio and video kernels. It treats each 64-bit operand as a row of independent lanes, eight, sixteen or thirty-two bits wide. On every lane it can form a rounded average, an absolute difference, an absolute difference added into an accumulator lane, or the smaller or larger of the two inputs. The signedness input picks unsigned or two's-complement ordering for the whole word.

For minimum and maximum, the unit can also record a 4-bit condition code. This code comes from comparing the two source operands in the lowest lane. It does not depend on which operand ended up in the result, so a minimum and a maximum on the same inputs record the same code. One operation can be issued on every clock, and its result appears on the outputs one clock later.

Top module: `pmx_alu`

## Requirements
- R1: Opcode 0 (average) gives each lane (a + b + 1) >> 1 with no carry lost, truncated to the lane width. With signedness 1 the shift is arithmetic, so 0x80 averaged with 0x80 in an 8-bit lane gives 0x80, and 0xFF with 0xFF gives 0xFF when unsigned.
- R2: Opcode 1 (absolute difference) gives a − b when a > b, and b − a otherwise, in the lane's ordering, truncated to the lane width. Signed 0x7F against 0x80 gives 0xFF.
- R3: Opcode 2 (difference accumulate) adds the R2 lane value to the matching lane of the accumulator operand, as unsigned numbers, and wraps modulo the lane width when the saturate input is 0.
- R4: With the saturate input at 1, opcode 2 clamps any lane sum that overflows to the all-ones lane value.
- R5: Opcode 3 (minimum) and opcode 4 (maximum) with signedness 0 pick the smaller or the larger lane under unsigned ordering.
- R6: With signedness 1, minimum and maximum use two's-complement ordering. The most negative value (for example 0x80 in an 8-bit lane) is below every other value.
- R7: The lane-width code selects 8-bit lanes (0), 16-bit lanes (1) or 32-bit lanes (2 and 3). No carry, borrow or comparison crosses a lane boundary.
- R8: When the record input is 1 and the opcode is 3 or 4, the condition output holds these bits. Bit 3 is source B < source A, bit 2 is source B > source A and bit 1 is equality, all judged on the lowest lane under the selected ordering. Bit 0 is set when the full 64-bit operands are equal. The code is the same for minimum and maximum.
- R9: The condition output is 0 when the record input is 0 or the opcode is not 3 or 4.
- R10: Result and condition are registered. They appear one clock after the inputs are sampled, and a new operation is taken on every clock.
- R11: During reset, result and condition are 0.
- R12: Opcodes 5 to 7 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| lane_sel_i | input | 2 | Lane width code |
| sgn_i | input | 1 | 1 = two's-complement lanes |
| rec_i | input | 1 | Record condition code for min/max |
| sat_i | input | 1 | Saturate the accumulate form |
| src_a_i | input | 64 | Source operand A |
| src_b_i | input | 64 | Source operand B |
| acc_i | input | 64 | Accumulator operand |
| result_o | output | 64 | Registered lane results |
| cond_o | output | 4 | Registered condition code |

## Verification
The bench targets the cases where a lane sum carries out of its width:
- an unsigned average of all-ones lanes, which a design that drops the carry halves wrongly;
- signed averages and differences that straddle the most negative value, which a design with logical shifts or unsigned compares gets wrong;
- accumulate overflow with the saturate input in both states.

It also mixes the three lane widths on the same operand patterns, so a carry that leaks into the next lane corrupts the upper lanes. It compares the condition code for minimum against maximum, which shows whether the code tracks the chosen result instead of the inputs. Long random runs with forced equal operands and extreme values check every clock against the behavioural model.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    localparam int DATA_W  = 64;
    localparam int COND_W  = 4;
    localparam int N_WIDTH = 3;   // lane widths 8, 16, 32

    typedef enum logic [2:0] {
        OP_AVG    = 3'd0,
        OP_ABSD   = 3'd1,
        OP_ABSACC = 3'd2,
        OP_MIN    = 3'd3,
        OP_MAX    = 3'd4
    } pmx_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [COND_W-1:0] cond;
    } pmx_state_t;

endpackage

// File: rtl/pmx_lane.sv
module pmx_lane
    import pmx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  pmx_op_e      op_i,
    input  logic         sgn_i,
    input  logic         sat_i,
    output logic [W-1:0] y_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] ax, bx;
    logic          a_gt_b;
    logic [W-1:0]  half_sum;
    logic [W-1:0]  mag;
    logic [XW-1:0] acc_sum;

    always_comb begin
        ax       = {sgn_i & a_i[W-1], a_i};
        bx       = {sgn_i & b_i[W-1], b_i};
        a_gt_b   = $signed(ax) > $signed(bx);
        // (a+b+1)>>1 == (a>>1) + (b>>1) + (a0|b0), shifts taken on the widened value
        half_sum = ax[XW-1:1] + bx[XW-1:1] + W'(a_i[0] | b_i[0]);
        mag      = a_gt_b ? (a_i - b_i) : (b_i - a_i);
        acc_sum  = {1'b0, c_i} + {1'b0, mag};
        unique case (op_i)
            OP_AVG:    y_o = half_sum;
            OP_ABSD:   y_o = mag;
            OP_ABSACC: y_o = (sat_i && acc_sum[W]) ? {W{1'b1}} : acc_sum[W-1:0];
            OP_MIN:    y_o = a_gt_b ? b_i : a_i;
            OP_MAX:    y_o = a_gt_b ? a_i : b_i;
            default:   y_o = '0;
        endcase
    end

    always_comb begin
        if (op_i == OP_MIN || op_i == OP_MAX)
            assert (y_o == a_i || y_o == b_i)
                else $error("AST_MINMAX_PICK"); // R5
    end

endmodule

// File: rtl/pmx_cond.sv
module pmx_cond
    import pmx_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        wsel_i,
    input  logic              sgn_i,
    output logic [COND_W-1:0] code_o
);
    logic [N_WIDTH-1:0] lt_w, gt_w, eq_w;

    for (genvar g = 0; g < N_WIDTH; g++) begin : g_w
        localparam int LW = 8 << g;
        logic [LW:0] ae, be;
        assign ae      = {sgn_i & a_i[LW-1], a_i[LW-1:0]};
        assign be      = {sgn_i & b_i[LW-1], b_i[LW-1:0]};
        assign lt_w[g] = $signed(be) < $signed(ae);
        assign gt_w[g] = $signed(be) > $signed(ae);
        assign eq_w[g] = (ae == be);
    end

    always_comb begin
        code_o = {lt_w[wsel_i], gt_w[wsel_i], eq_w[wsel_i], a_i == b_i};
    end

    always_comb begin
        assert ($countones(code_o[3:1]) == 1) else $error("AST_COND_ONE_REL"); // R8
    end

endmodule

// File: rtl/pmx_alu.sv
module pmx_alu
    import pmx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        op_i,
    input  logic [1:0]        lane_sel_i,
    input  logic              sgn_i,
    input  logic              rec_i,
    input  logic              sat_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic [DATA_W-1:0] result_o,
    output logic [COND_W-1:0] cond_o
);
    pmx_op_e           op_e;
    logic [1:0]        widx;
    logic [DATA_W-1:0] res_by_w [N_WIDTH];
    logic [COND_W-1:0] code;
    pmx_state_t        st_d, st_q;

    assign op_e = pmx_op_e'(op_i);
    assign widx = (lane_sel_i == 2'd3) ? 2'd2 : lane_sel_i;

    for (genvar g = 0; g < N_WIDTH; g++) begin : g_width
        localparam int LW = 8 << g;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            pmx_lane #(.W(LW)) u_lane (
                .a_i   (src_a_i[l*LW +: LW]),
                .b_i   (src_b_i[l*LW +: LW]),
                .c_i   (acc_i[l*LW +: LW]),
                .op_i  (op_e),
                .sgn_i (sgn_i),
                .sat_i (sat_i),
                .y_o   (res_by_w[g][l*LW +: LW])
            );
        end
    end

    pmx_cond u_cond (
        .a_i    (src_a_i),
        .b_i    (src_b_i),
        .wsel_i (widx),
        .sgn_i  (sgn_i),
        .code_o (code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.res  = res_by_w[widx];
        st_d.cond = (rec_i && (op_e == OP_MIN || op_e == OP_MAX)) ? code : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign cond_o   = st_q.cond;

    AST_AVG_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd0 && src_a_i == src_b_i) |=> (result_o == $past(src_a_i))); // R1
    AST_ABSD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd1 && src_a_i == src_b_i) |=> (result_o == '0)); // R2
    AST_COND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rec_i && (op_i == 3'd3 || op_i == 3'd4)) |=> (cond_o == '0)); // R9
    AST_COND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rec_i && (op_i == 3'd3 || op_i == 3'd4)) |=> ($countones(cond_o[3:1]) == 1)); // R8
    AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i > 3'd4) |=> (result_o == '0)); // R12
    AST_ACC_SAT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd2 && sat_i && lane_sel_i == 2'd0 && acc_i[7:0] == 8'hFF)
        |=> (result_o[7:0] == 8'hFF)); // R4

endmodule

// File: tb/tb_pmx_alu.sv
module tb_pmx_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  lsel = '0;
    logic        sgn = 1'b0, rec = 1'b0, sat = 1'b0;
    logic [63:0] a = '0, b = '0, c = '0;
    logic [63:0] result;
    logic [3:0]  cond;

    int checks = 0;
    int fails  = 0;

    logic        pend = 1'b0;
    logic [63:0] exp_res;
    logic [3:0]  exp_cond;
    string       exp_tag;

    always #4 clk = ~clk;   // 125 MHz

    pmx_alu dut (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .lane_sel_i(lsel),
        .sgn_i(sgn), .rec_i(rec), .sat_i(sat),
        .src_a_i(a), .src_b_i(b), .acc_i(c),
        .result_o(result), .cond_o(cond)
    );

    function automatic int lane_w(logic [1:0] code);
        return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
    endfunction

    function automatic longint lane_val(logic [63:0] v, int i, int w, bit s);
        longint m = (longint'(1) << w) - 1;
        longint x = longint'(v >> (i * w)) & m;
        if (s && x >= (longint'(1) << (w - 1))) x = x - (longint'(1) << w);
        return x;
    endfunction

    function automatic logic [63:0] model_res(int o, int w, bit s, bit st,
                                              logic [63:0] va, logic [63:0] vb, logic [63:0] vc);
        logic [63:0] r = '0;
        longint m = (longint'(1) << w) - 1;
        for (int i = 0; i < 64 / w; i++) begin
            longint av = lane_val(va, i, w, s);
            longint bv = lane_val(vb, i, w, s);
            longint cv = lane_val(vc, i, w, 1'b0);
            longint d  = (av > bv) ? av - bv : bv - av;
            longint y;
            case (o)
                0: y = (av + bv + 1) >>> 1;
                1: y = d;
                2: begin y = cv + d; if (st && y > m) y = m; end
                3: y = (av < bv) ? av : bv;
                4: y = (av > bv) ? av : bv;
                default: y = 0;
            endcase
            r = r | (64'(y & m) << (i * w));
        end
        return r;
    endfunction

    function automatic logic [3:0] model_cond(int o, int w, bit s, bit rc,
                                             logic [63:0] va, logic [63:0] vb);
        longint av = lane_val(va, 0, w, s);
        longint bv = lane_val(vb, 0, w, s);
        if (!rc || (o != 3 && o != 4)) return 4'd0;
        return {bv < av, bv > av, bv == av, va == vb};
    endfunction

    task automatic check_pending();
        if (!pend) return;
        checks++;
        if (result !== exp_res || cond !== exp_cond) begin
            fails++;
            $display("FAIL %s R10: actual res=%h cond=%b expected res=%h cond=%b",
                     exp_tag, result, cond, exp_res, exp_cond);
        end
    endtask

    // drive at negedge, after checking the previous cycle's registered output
    task automatic apply(int o, logic [1:0] ls, bit s, bit rc, bit st,
                         logic [63:0] va, logic [63:0] vb, logic [63:0] vc, string tag);
        @(negedge clk);
        check_pending();
        op = 3'(o); lsel = ls; sgn = s; rec = rc; sat = st; a = va; b = vb; c = vc;
        exp_res  = model_res(o, lane_w(ls), s, st, va, vb, vc);
        exp_cond = model_cond(o, lane_w(ls), s, rc, va, vb);
        exp_tag  = tag;
        pend     = 1'b1;
    endtask

    function automatic string op_tag(int o, bit s, bit st);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return st ? "R4" : "R3";
            3, 4: return s ? "R6" : "R5";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [63:0] pick_val();
        case ($urandom_range(0, 5))
            0: return 64'h0;
            1: return '1;
            2: return 64'h8080_8080_8080_8080;
            3: return 64'h7F7F_7FFF_7FFF_FFFF;
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        a = '1; b = 64'h1234; op = 3'd3; rec = 1'b1;
        repeat (3) @(negedge clk);
        checks++;   // R11 reset state
        if (result !== '0 || cond !== '0) begin
            fails++;
            $display("FAIL R11: actual res=%h cond=%b expected res=0 cond=0", result, cond);
        end
        rst_n = 1'b1;

        // R1 carry kept, signed rounding
        apply(0, 2'd0, 0, 0, 0, '1, '1, 0, "R1");
        apply(0, 2'd0, 1, 0, 0, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 0, "R1");
        apply(0, 2'd0, 1, 0, 0, 64'h7F7F_7F7F_7F7F_7F7F, 64'h8080_8080_8080_8080, 0, "R1");
        apply(0, 2'd1, 0, 0, 0, 64'h0001_FFFF_0003_8000, 64'h0000_FFFF_0000_8001, 0, "R1");
        // R2 signed/unsigned difference
        apply(1, 2'd0, 1, 0, 0, 64'h7F, 64'h80, 0, "R2");
        apply(1, 2'd0, 0, 0, 0, 64'h10_7F, 64'h30_80, 0, "R2");
        // R3 wrap, R4 saturate
        apply(2, 2'd0, 0, 0, 0, 64'h20, 64'h00, 64'hF0, "R3");
        apply(2, 2'd0, 0, 0, 1, 64'h20, 64'h00, 64'hF0, "R4");
        apply(2, 2'd1, 1, 0, 1, 64'h8000_7FFF, 64'h7FFF_8000, 64'h0001_0001, "R4");
        // R5/R6 ordering at the most negative value
        apply(3, 2'd0, 1, 0, 0, 64'h80, 64'h7F, 0, "R6");
        apply(3, 2'd0, 0, 0, 0, 64'h80, 64'h7F, 0, "R5");
        apply(4, 2'd2, 1, 0, 0, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 0, "R6");
        // R7 lane independence across the width codes
        for (int k = 0; k < 4; k++)
            apply(0, 2'(k), 0, 0, 0, '1, 64'h0101_0101_0101_0101, 0, "R7");
        apply(1, 2'd3, 0, 0, 0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 0, "R7");
        // R8 same code from min and max; R9 quiet cases
        apply(3, 2'd0, 1, 1, 0, 64'h05, 64'h80, 0, "R8");
        apply(4, 2'd0, 1, 1, 0, 64'h05, 64'h80, 0, "R8");
        apply(4, 2'd0, 0, 1, 0, 64'h1100, 64'h2200, 0, "R8");
        apply(3, 2'd1, 0, 1, 0, 64'h42, 64'h42, 0, "R8");
        apply(3, 2'd0, 0, 0, 0, 64'h05, 64'h80, 0, "R9");
        apply(1, 2'd0, 0, 1, 0, 64'h05, 64'h80, 0, "R9");
        // R12 reserved codes
        for (int o = 5; o < 8; o++)
            apply(o, 2'd0, 0, 1, 1, '1, 64'h3, '1, "R12");

        // R10 back-to-back random traffic
        for (int n = 0; n < 4000; n++) begin
            int          o  = $urandom_range(0, 7);
            bit          s  = 1'($urandom_range(0, 1));
            bit          st = 1'($urandom_range(0, 1));
            logic [63:0] va = pick_val();
            logic [63:0] vb = ($urandom_range(0, 7) == 0) ? va : pick_val();
            apply(o, 2'($urandom_range(0, 3)), s, 1'($urandom_range(0, 1)), st,
                  va, vb, pick_val(), op_tag(o, s, st));
        end
        @(negedge clk);
        check_pending();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule